// File: doc/BRIEF.md
# Spike Batching Transmit Packetizer

This block assembles 512-bit words for a host-bound transmit FIFO. While a network run is active it drains a spike FIFO of 17-bit neuron addresses, turns each address into a 32-bit record stamped with the low byte of the current step counter, and gathers up to fourteen records in a batch register. A batch goes out as one packet when it fills. It also goes out when the run signals completion while records are still held. The packet is framed by a fixed 32-bit marker at the top and the full step counter at the bottom.

While no run is active, the same transmit port carries read responses instead. A 256-bit synapse-memory response or a 53-bit neuron response is wrapped into a 512-bit word with its own 16-bit header. The synapse source is always served first. All three input FIFOs are first-word fall-through: data is valid whenever the empty flag is low, and a pop consumes it at the next clock edge. The transmit write and the pops are issued in the same cycle that the packet is presented.

Top module: `spike_tx_packer`

## Requirements
- R1: While `rst_n` is low and until the block reaches idle, `tx_wr` and all three pops stay low and `dbg_state` reads 0. A few cycles after release, `dbg_state` reads 1.
- R2: A spike record is `{step_count[7:0], 1'b1, 7'b0, spk_addr[15:0]}`, using the step counter value in the cycle of the pop. Address bit 16 is dropped.
- R3: In the collect state, one spike is popped in every cycle where the spike FIFO is not empty and fewer than 14 records are held. No spike is popped outside the collect state.
- R4: A full batch is written as `{32'hEEEE_EEEE, records, step_count}`. The first record popped sits in bits [63:32] and the fourteenth in bits [479:448].
- R5: When `run_done` is seen in the collect state with the spike FIFO empty and 1 to 13 records held, the partial batch is written. Its k records fill the top k slots in arrival order, and every lower slot is zero.
- R6: When `run_done` is seen in the collect state with the FIFO empty and no records held, the block returns to idle (`dbg_state` 1) and writes nothing.
- R7: No write happens while `tx_full` is high. A pending batch is held in the send state, and no spike is popped until the batch has been written.
- R8: A synapse response is written as `{16'hBBBB, 240'b0, syn_rsp_data}`, with `syn_rsp_pop` high in the same cycle.
- R9: A neuron response is written as `{16'hCCCC, 443'b0, nrn_rsp_data}`, with `nrn_rsp_pop` high in the same cycle.
- R10: Responses are forwarded only from idle, with `run_active` low and `tx_full` low. When both response sources hold data, the synapse response goes first.
- R11: `dbg_state` encodes reset = 0, idle = 1, collect = 2, send = 3. The block enters collect from idle when `run_active` is high, and it returns to idle after every spike packet.
- R12: After a spike packet is written, the batch is empty. The next packet carries none of the earlier records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_active | input | 1 | A network run is in progress |
| run_done | input | 1 | The run has finished |
| step_count | input | 32 | Current time-step counter |
| spk_empty | input | 1 | Spike FIFO empty |
| spk_addr | input | 17 | Head of spike FIFO: neuron address |
| spk_pop | output | 1 | Spike FIFO read enable |
| syn_rsp_empty | input | 1 | Synapse response FIFO empty |
| syn_rsp_data | input | 256 | Head of synapse response FIFO |
| syn_rsp_pop | output | 1 | Synapse response read enable |
| nrn_rsp_empty | input | 1 | Neuron response FIFO empty |
| nrn_rsp_data | input | 53 | Head of neuron response FIFO |
| nrn_rsp_pop | output | 1 | Neuron response read enable |
| tx_full | input | 1 | Transmit FIFO full |
| tx_data | output | 512 | Transmit FIFO write data |
| tx_wr | output | 1 | Transmit FIFO write enable |
| dbg_state | output | 2 | Current control state |

## Verification
The hardest situation to reach is a full batch stalled by transmit backpressure while more spikes are waiting. Only in that state is it visible whether the fifteenth spike is wrongly popped and lost. The stimulus holds `tx_full` high before a run starts and queues fifteen spikes. After the fourteen pops it checks that the send state persists, that nothing was written and that one spike is still queued. It then releases backpressure and follows the leftover spike into a flushed partial batch.

// File: rtl/tx_pkt_pkg.sv
package tx_pkt_pkg;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_IDLE    = 2'd1,
    ST_COLLECT = 2'd2,
    ST_SEND    = 2'd3
  } tx_state_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SPIKE = 2'd1,
    SRC_SYN   = 2'd2,
    SRC_NRN   = 2'd3
  } tx_src_e;

  localparam logic [31:0] SPIKE_MARK = 32'hEEEE_EEEE;
  localparam logic [15:0] SYN_HDR    = 16'hBBBB;
  localparam logic [15:0] NRN_HDR    = 16'hCCCC;

endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  // Assertion is immediate; release travels through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/spike_record_fmt.sv
module spike_record_fmt #(
  parameter int REC_W   = 32,
  parameter int TS_W    = 8,
  parameter int FIELD_W = 16
) (
  input  logic [TS_W-1:0]    stamp,
  input  logic [FIELD_W-1:0] neuron,
  output logic [REC_W-1:0]   rec
);

  localparam int PAD_W = REC_W - TS_W - 1 - FIELD_W;

  // Sub-timestamp on top, valid bit, zero padding, neuron address below.
  always_comb begin
    rec = {stamp, 1'b1, {PAD_W{1'b0}}, neuron};
  end

endmodule

// File: rtl/spike_batch_reg.sv
module spike_batch_reg #(
  parameter int REC_W = 32,
  parameter int SLOTS = 14,
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int BATCH_W = REC_W * SLOTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clr,
  input  logic [REC_W-1:0]   rec_in,
  output logic [BATCH_W-1:0] batch,
  output logic               full,
  output logic               any
);

  logic [BATCH_W-1:0] batch_q;
  logic [CNT_W-1:0]   cnt_q;

  // New records enter at the top slot; older ones move down one slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      batch_q <= '0;
    end else if (clr) begin
      batch_q <= '0;
    end else if (shift_en) begin
      batch_q <= {rec_in, batch_q[BATCH_W-1:REC_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign batch = batch_q;
  assign full  = (cnt_q == CNT_W'(SLOTS));
  assign any   = (cnt_q != '0);

endmodule

// File: rtl/tx_ctrl_fsm.sv
module tx_ctrl_fsm
  import tx_pkt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_active,
  input  logic      run_done,
  input  logic      spk_empty,
  input  logic      syn_empty,
  input  logic      nrn_empty,
  input  logic      tx_full,
  input  logic      batch_full,
  input  logic      batch_any,
  output tx_state_e state,
  output logic      spk_pop,
  output logic      syn_pop,
  output logic      nrn_pop,
  output logic      batch_clr,
  output logic      tx_wr,
  output tx_src_e   tx_src
);

  tx_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    spk_pop   = 1'b0;
    syn_pop   = 1'b0;
    nrn_pop   = 1'b0;
    batch_clr = 1'b0;
    tx_wr     = 1'b0;
    tx_src    = SRC_NONE;
    unique case (state_q)
      ST_RESET: state_d = ST_IDLE;
      ST_IDLE: begin
        if (run_active) begin
          state_d = ST_COLLECT;
        end else if (!tx_full) begin
          if (!syn_empty) begin
            syn_pop = 1'b1;
            tx_wr   = 1'b1;
            tx_src  = SRC_SYN;
          end else if (!nrn_empty) begin
            nrn_pop = 1'b1;
            tx_wr   = 1'b1;
            tx_src  = SRC_NRN;
          end
        end
      end
      ST_COLLECT: begin
        // Full batch first, then drain spikes, then honour completion.
        if (batch_full) begin
          state_d = ST_SEND;
        end else if (!spk_empty) begin
          spk_pop = 1'b1;
        end else if (run_done) begin
          state_d = batch_any ? ST_SEND : ST_IDLE;
        end
      end
      ST_SEND: begin
        if (!tx_full) begin
          tx_wr     = 1'b1;
          tx_src    = SRC_SPIKE;
          batch_clr = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/spike_tx_packer.sv
module spike_tx_packer
  import tx_pkt_pkg::*;
#(
  parameter int PKT_W  = 512,
  parameter int REC_W  = 32,
  parameter int SLOTS  = 14,
  parameter int ADDR_W = 17,
  parameter int STEP_W = 32,
  parameter int SYN_W  = 256,
  parameter int NRN_W  = 53,
  parameter int TS_W   = 8,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_active,
  input  logic              run_done,
  input  logic [STEP_W-1:0] step_count,
  input  logic              spk_empty,
  input  logic [ADDR_W-1:0] spk_addr,
  output logic              spk_pop,
  input  logic              syn_rsp_empty,
  input  logic [SYN_W-1:0]  syn_rsp_data,
  output logic              syn_rsp_pop,
  input  logic              nrn_rsp_empty,
  input  logic [NRN_W-1:0]  nrn_rsp_data,
  output logic              nrn_rsp_pop,
  input  logic              tx_full,
  output logic [PKT_W-1:0]  tx_data,
  output logic              tx_wr,
  output logic [1:0]        dbg_state
);

  localparam int BATCH_W = REC_W * SLOTS;
  localparam int HDR_W   = 16;
  localparam int SYN_PAD = PKT_W - HDR_W - SYN_W;
  localparam int NRN_PAD = PKT_W - HDR_W - NRN_W;

  logic               rst_n_int;
  logic [REC_W-1:0]   rec;
  logic [BATCH_W-1:0] batch;
  logic               batch_full, batch_any, batch_clr;
  tx_state_e          state;
  tx_src_e            src;

  tx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  spike_record_fmt #(.REC_W(REC_W), .TS_W(TS_W), .FIELD_W(FLD_W)) u_fmt (
    .stamp  (step_count[TS_W-1:0]),
    .neuron (spk_addr[FLD_W-1:0]),
    .rec    (rec)
  );

  spike_batch_reg #(.REC_W(REC_W), .SLOTS(SLOTS)) u_batch (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (spk_pop),
    .clr      (batch_clr),
    .rec_in   (rec),
    .batch    (batch),
    .full     (batch_full),
    .any      (batch_any)
  );

  tx_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .run_active (run_active),
    .run_done   (run_done),
    .spk_empty  (spk_empty),
    .syn_empty  (syn_rsp_empty),
    .nrn_empty  (nrn_rsp_empty),
    .tx_full    (tx_full),
    .batch_full (batch_full),
    .batch_any  (batch_any),
    .state      (state),
    .spk_pop    (spk_pop),
    .syn_pop    (syn_rsp_pop),
    .nrn_pop    (nrn_rsp_pop),
    .batch_clr  (batch_clr),
    .tx_wr      (tx_wr),
    .tx_src     (src)
  );

  always_comb begin
    unique case (src)
      SRC_SPIKE: tx_data = {SPIKE_MARK, batch, step_count};
      SRC_SYN:   tx_data = {SYN_HDR, {SYN_PAD{1'b0}}, syn_rsp_data};
      SRC_NRN:   tx_data = {NRN_HDR, {NRN_PAD{1'b0}}, nrn_rsp_data};
      default:   tx_data = '0;
    endcase
  end

  assign dbg_state = state;

endmodule

// File: rtl/tx_packer_checker.sv
module tx_packer_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         run_active,
  input logic         spk_empty,
  input logic [16:0]  spk_addr,
  input logic         spk_pop,
  input logic         syn_rsp_empty,
  input logic         syn_rsp_pop,
  input logic         nrn_rsp_pop,
  input logic         tx_full,
  input logic [511:0] tx_data,
  input logic         tx_wr,
  input logic [1:0]   dbg_state
);

  assert_addr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spk_pop |-> !$isunknown(spk_addr));

  assert_pop_in_collect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spk_pop |-> (dbg_state == 2'd2 && !spk_empty));

  assert_spike_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && dbg_state == 2'd3) |-> (tx_data[511:480] == 32'hEEEE_EEEE));

  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> !tx_full);

  assert_hold_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 2'd3 && tx_full) |=> (dbg_state == 2'd3));

  assert_syn_header_R8: assert property (@(posedge clk) disable iff (!rst_n)
    syn_rsp_pop |-> (tx_wr && tx_data[511:496] == 16'hBBBB));

  assert_syn_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    syn_rsp_pop |-> (dbg_state == 2'd1 && !run_active));

  assert_syn_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nrn_rsp_pop |-> syn_rsp_empty);

  assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spk_pop, syn_rsp_pop, nrn_rsp_pop}));

endmodule

bind spike_tx_packer tx_packer_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_active    (run_active),
  .spk_empty     (spk_empty),
  .spk_addr      (spk_addr),
  .spk_pop       (spk_pop),
  .syn_rsp_empty (syn_rsp_empty),
  .syn_rsp_pop   (syn_rsp_pop),
  .nrn_rsp_pop   (nrn_rsp_pop),
  .tx_full       (tx_full),
  .tx_data       (tx_data),
  .tx_wr         (tx_wr),
  .dbg_state     (dbg_state)
);

// File: tb/tb_spike_tx_packer.sv
module tb_spike_tx_packer;

  localparam time CLK_PERIOD = 10ns;

  logic         clk;
  logic         rst_n;
  logic         run_active, run_done;
  logic [31:0]  step_count;
  logic         spk_empty, spk_pop;
  logic [16:0]  spk_addr;
  logic         syn_rsp_empty, syn_rsp_pop;
  logic [255:0] syn_rsp_data;
  logic         nrn_rsp_empty, nrn_rsp_pop;
  logic [52:0]  nrn_rsp_data;
  logic         tx_full, tx_wr;
  logic [511:0] tx_data;
  logic [1:0]   dbg_state;

  spike_tx_packer dut (
    .clk(clk), .rst_n(rst_n), .run_active(run_active), .run_done(run_done),
    .step_count(step_count), .spk_empty(spk_empty), .spk_addr(spk_addr),
    .spk_pop(spk_pop), .syn_rsp_empty(syn_rsp_empty), .syn_rsp_data(syn_rsp_data),
    .syn_rsp_pop(syn_rsp_pop), .nrn_rsp_empty(nrn_rsp_empty),
    .nrn_rsp_data(nrn_rsp_data), .nrn_rsp_pop(nrn_rsp_pop), .tx_full(tx_full),
    .tx_data(tx_data), .tx_wr(tx_wr), .dbg_state(dbg_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bench-side FIFO models and packet capture.
  logic [16:0]  spk_q[$];
  logic [255:0] syn_q[$];
  logic [52:0]  nrn_q[$];
  logic [511:0] pkts[$];
  logic         spk_took, syn_took, nrn_took;
  int           pop_total;
  int           checks, fails;
  bit           done_flag;

  always @(posedge clk) begin
    spk_took <= spk_pop;
    syn_took <= syn_rsp_pop;
    nrn_took <= nrn_rsp_pop;
    if (spk_pop) pop_total <= pop_total + 1;
    if (tx_wr) pkts.push_back(tx_data);
  end

  task automatic refresh();
    spk_empty     = (spk_q.size() == 0);
    spk_addr      = spk_empty ? 17'd0 : spk_q[0];
    syn_rsp_empty = (syn_q.size() == 0);
    syn_rsp_data  = syn_rsp_empty ? 256'd0 : syn_q[0];
    nrn_rsp_empty = (nrn_q.size() == 0);
    nrn_rsp_data  = nrn_rsp_empty ? 53'd0 : nrn_q[0];
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (spk_took && spk_q.size() > 0) void'(spk_q.pop_front());
      if (syn_took && syn_q.size() > 0) void'(syn_q.pop_front());
      if (nrn_took && nrn_q.size() > 0) void'(nrn_q.pop_front());
      refresh();
    end
  endtask

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkrec(input logic [16:0] a, input logic [31:0] s);
    return {s[7:0], 1'b1, 7'd0, a[15:0]};
  endfunction

  task automatic end_run();
    run_done = 1'b1; run_active = 1'b0;
    tick(1);
    run_done = 1'b0;
    tick(3);
  endtask

  // {neuron address, step counter, expected record}
  localparam logic [80:0] REC_TBL [4] = '{
    {17'h00005, 32'h0000_0003, 32'h0380_0005},
    {17'h1FFFF, 32'h1234_56AB, 32'hAB80_FFFF},
    {17'h10000, 32'hFFFF_FF00, 32'h0080_0000},
    {17'h0A5C3, 32'h0000_00FF, 32'hFF80_A5C3}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] p;
    logic [31:0]  st;
    checks = 0; fails = 0; pop_total = 0; done_flag = 1'b0;
    spk_took = 1'b0; syn_took = 1'b0; nrn_took = 1'b0;
    rst_n = 1'b0; run_active = 1'b0; run_done = 1'b0; step_count = '0; tx_full = 1'b0;
    refresh();
    tick(4);
    // R1 reset state
    chk("R1 dbg_state in reset", 512'(dbg_state), 512'd0);
    chk("R1 no write in reset", 512'(tx_wr), 512'd0);
    chk("R1 no pops in reset", 512'({spk_pop, syn_rsp_pop, nrn_rsp_pop}), 512'd0);
    rst_n = 1'b1;
    tick(6);
    chk("R11 idle after reset", 512'(dbg_state), 512'd1);

    // R2 / R5: table walk, one spike per run flushed on completion
    foreach (REC_TBL[k]) begin
      int n0;
      n0 = pkts.size();
      step_count = REC_TBL[k][63:32];
      spk_q.push_back(REC_TBL[k][80:64]);
      refresh();
      run_active = 1'b1;
      tick(2);
      chk("R11 collect while running", 512'(dbg_state), 512'd2);
      tick(3);
      end_run();
      chk("R5 one flushed packet", 512'(pkts.size() - n0), 512'd1);
      p = pkts[pkts.size() - 1];
      chk("R2 record in top slot", 512'(p[479:448]), 512'(REC_TBL[k][31:0]));
      chk("R5 lower slots zero", 512'(p[447:32]), 512'd0);
      chk("R4 step counter field", 512'(p[31:0]), 512'(REC_TBL[k][63:32]));
    end

    // R3 / R4 / R12: 16 spikes -> full batch plus partial remainder
    begin
      int n0, p0;
      n0 = pkts.size(); p0 = pop_total;
      st = 32'hCAFE_0042; step_count = st;
      for (int i = 0; i < 16; i++) spk_q.push_back(17'h100 + 17'(i * 37));
      refresh();
      run_active = 1'b1;
      tick(25);
      end_run();
      chk("R3 all spikes popped", 512'(pop_total - p0), 512'd16);
      chk("R4 two packets", 512'(pkts.size() - n0), 512'd2);
      p = pkts[n0];
      chk("R4 marker", 512'(p[511:480]), 512'(32'hEEEE_EEEE));
      for (int i = 0; i < 14; i++)
        chk("R4 slot order", 512'(p[32 + 32*i +: 32]), 512'(mkrec(17'h100 + 17'(i * 37), st)));
      p = pkts[n0 + 1];
      chk("R12 slot 12 is spike 15", 512'(p[416 +: 32]), 512'(mkrec(17'h100 + 17'(14 * 37), st)));
      chk("R12 slot 13 is spike 16", 512'(p[448 +: 32]), 512'(mkrec(17'h100 + 17'(15 * 37), st)));
      chk("R12 old records cleared", 512'(p[415:32]), 512'd0);
    end

    // R7: backpressure holds a full batch and stops popping
    begin
      int n0;
      n0 = pkts.size();
      st = 32'h0000_0777; step_count = st;
      tx_full = 1'b1;
      for (int i = 0; i < 15; i++) spk_q.push_back(17'h00200 + 17'(i));
      refresh();
      run_active = 1'b1;
      tick(25);
      chk("R7 no write while full", 512'(pkts.size() - n0), 512'd0);
      chk("R7 held in send", 512'(dbg_state), 512'd3);
      chk("R7 fifteenth spike not popped", 512'(spk_q.size()), 512'd1);
      tx_full = 1'b0;
      tick(2);
      chk("R7 written after release", 512'(pkts.size() - n0), 512'd1);
      tick(6);
      end_run();
      chk("R7 leftover flushed", 512'(pkts.size() - n0), 512'd2);
      p = pkts[n0 + 1];
      chk("R7 leftover record", 512'(p[479:448]), 512'(mkrec(17'h0020E, st)));
    end

    // R6 / R10: response waits during run; empty completion writes nothing
    begin
      int n0;
      n0 = pkts.size();
      run_active = 1'b1;
      syn_q.push_back({8{32'h5A5A_0001}});
      refresh();
      tick(5);
      chk("R10 no forward while running", 512'(syn_q.size()), 512'd1);
      run_done = 1'b1;
      tick(1);
      run_done = 1'b0;
      chk("R6 idle after empty completion", 512'(dbg_state), 512'd1);
      chk("R6 no packet written", 512'(pkts.size() - n0), 512'd0);
      run_active = 1'b0;
      tick(3);
      chk("R8 synapse forwarded", 512'(pkts.size() - n0), 512'd1);
    end

    // R8 / R9 / R10: priority and backpressure on responses
    begin
      int n0;
      logic [255:0] sd;
      logic [52:0]  nd;
      sd = {4{64'h0123_4567_89AB_CDEF}};
      nd = 53'h1F_FFFF_0000_1234;
      n0 = pkts.size();
      tx_full = 1'b1;
      nrn_q.push_back(nd);
      syn_q.push_back(sd);
      refresh();
      tick(5);
      chk("R10 no forward while tx full", 512'(pkts.size() - n0), 512'd0);
      tx_full = 1'b0;
      tick(4);
      chk("R10 both forwarded", 512'(pkts.size() - n0), 512'd2);
      chk("R8 synapse first and format", pkts[n0], {16'hBBBB, 240'd0, sd});
      chk("R9 neuron format", pkts[n0 + 1], {16'hCCCC, 443'd0, nd});
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule